// File: doc/BRIEF.md
# Synchronous FIFO Write Slave

This block is the receiving end of a synchronous 32-bit parallel write bus where the slave owns the clock. It forwards its own clock to the external master as the bus clock. On every rising edge where the master holds the active-low write strobe low, it takes in one 32-bit word together with four per-lane byte enables. The enabled bytes are packed, lowest lane first, into an internal byte ring. Words whose enables are all clear add nothing.

The slave throttles the master with an active-low space flag. The flag is raised while fewer than two full words of room remain. A master that notices the flag one cycle late therefore still lands its extra word safely. A burst is the run of consecutive strobed cycles, and it ends on the first edge where the strobe is high. Each burst leaves the block as one packet on a byte-wide valid/ready stream, with the last byte marked. The most recent byte of a burst that is still open is held back, so that the end marker can be placed on it once the burst closes.

The output stream obeys the usual back-pressure rules. Once valid is high, the byte and its last marker stay put until ready is seen high at a clock edge. One byte moves per handshake, and bytes come out in the order they arrived, across burst boundaries too.

Top module: `sfw_write_slave`

## Requirements
- R1: During and right after reset the space flag `txe_n_o` is 0 (room available) and `m_valid_o` is 0.
- R2: A word is taken on every rising edge with `wr_n_i` low. Its bytes with `be_i[j]`=1 are appended in rising lane order; lane j is `data_i[8j+7:8j]`. For example, enables 4'b1010 append lane 1 and then lane 3.
- R3: `txe_n_o` is 1 exactly when the free room (DEPTH minus bytes stored, the held byte included) is below 2*LANES bytes. With DEPTH=32 and LANES=4, it stays 0 after six full words and reads 1 after the seventh.
- R4: A master that decides each write from the flag value of one cycle earlier never loses a byte.
- R5: A burst ends on the first edge with `wr_n_i` high. Its final byte leaves with `m_last_o`=1, and every other byte leaves with `m_last_o`=0.
- R6: While a burst is open, its most recently stored byte is not offered on the stream. It becomes visible in the cycle after the burst ends.
- R7: A word with all enables clear adds no byte. If it is the final word, the end marker falls on the burst's previous byte. A burst with no enabled bytes produces no output.
- R8: While `m_valid_o`=1 and `m_ready_i`=0, the next cycle still shows `m_valid_o`=1 with the same `m_data_o` and `m_last_o`. Bytes are delivered in arrival order.
- R9: `bus_clk_o` follows `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also forwarded to the master |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk_o | output | 1 | Bus clock driven to the master |
| wr_n_i | input | 1 | Active-low write strobe from the master |
| data_i | input | 32 | Write data word, four byte lanes |
| be_i | input | 4 | Per-lane byte enables, active high |
| txe_n_o | output | 1 | Active-low space-available flag |
| m_valid_o | output | 1 | Output stream byte valid |
| m_data_o | output | 8 | Output stream byte |
| m_last_o | output | 1 | Marks the final byte of a burst |
| m_ready_i | input | 1 | Output stream ready from the consumer |

## Verification
The bench uses the default DEPTH=32 and LANES=4. With these values the space threshold of eight bytes is reached within seven words. Table bursts of 40 and 64 bytes overrun the ring under slow or random ready, so they are split by the flag and exercise the lag-tolerant threshold with masters that react on time and masters that react one cycle late. Partial final words, non-contiguous enables and empty words reach the packing and end-marker corner cases.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sfw_lane_pack.sv
module sfw_lane_pack #(
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES*8-1:0] data_i,
  input  logic [LANES-1:0]   be_i,
  output logic [LANES*8-1:0] packed_o,
  output logic [CNT_W-1:0]   cnt_o
);
  // Compact enabled lanes toward slot 0, keeping lane order.
  always_comb begin
    packed_o = '0;
    cnt_o    = '0;
    for (int j = 0; j < LANES; j++) begin
      if (be_i[j]) begin
        packed_o[cnt_o*8 +: 8] = data_i[j*8 +: 8];
        cnt_o = cnt_o + CNT_W'(1);
      end
    end
  end

  // R2: byte count equals the number of enabled lanes
  always_comb begin
    if (!$isunknown(be_i))
      p_pack_count_r2: assert (int'(cnt_o) == $countones(be_i));
  end
endmodule

// File: rtl/sfw_byte_ring.sv
module sfw_byte_ring #(
  parameter int DEPTH  = 32,
  parameter int LANES  = 4,
  parameter int CNT_W  = $clog2(LANES + 1),
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [CNT_W-1:0]   wr_cnt_i,
  input  logic [LANES*8-1:0] wr_bytes_i,
  input  logic               idle_i,
  output logic               rd_valid_o,
  output sfw_pkg::byte_t     rd_data_o,
  output logic               rd_last_o,
  input  logic               rd_ready_i,
  output logic [FILL_W-1:0]  fill_o
);
  localparam int AW = $clog2(DEPTH);

  sfw_pkg::byte_t    mem [DEPTH];
  logic [DEPTH-1:0]  lastf;
  logic [AW-1:0]     wptr, rptr, last_q;
  logic [FILL_W-1:0] count;
  logic              open_q;
  logic              pop;
  logic              has_bytes;

  assign has_bytes  = wr_en_i && (wr_cnt_i != '0);
  // Newest byte of an open burst stays hidden until the burst closes.
  assign rd_valid_o = count > FILL_W'(open_q);
  assign rd_data_o  = mem[rptr];
  assign rd_last_o  = lastf[rptr];
  assign pop        = rd_valid_o && rd_ready_i;
  assign fill_o     = count;

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (wr_en_i && (CNT_W'(k) < wr_cnt_i)) begin
        mem[wptr + AW'(k)]   <= wr_bytes_i[k*8 +: 8];
        lastf[wptr + AW'(k)] <= 1'b0;
      end
    end
    if (idle_i && open_q) lastf[last_q] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      last_q <= '0;
      count  <= '0;
      open_q <= 1'b0;
    end else begin
      if (wr_en_i) wptr <= wptr + AW'(wr_cnt_i);
      if (pop)     rptr <= rptr + AW'(1);
      count <= count + (wr_en_i ? FILL_W'(wr_cnt_i) : FILL_W'(0)) - FILL_W'(pop);
      if (has_bytes) begin
        open_q <= 1'b1;
        last_q <= wptr + AW'(wr_cnt_i) - AW'(1);
      end else if (idle_i) begin
        open_q <= 1'b0;
      end
    end
  end

  // R8: offered byte holds while the consumer stalls
  p_stream_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));

  // R6: the byte held back becomes visible once its burst closes
  p_close_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> rd_valid_o);
endmodule

// File: rtl/sfw_write_slave.sv
module sfw_write_slave #(
  parameter int LANES = 4,
  parameter int DEPTH = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic           bus_clk_o,
  input  logic           wr_n_i,
  input  logic [31:0]    data_i,
  input  logic [3:0]     be_i,
  output logic           txe_n_o,
  output logic           m_valid_o,
  output logic [7:0]     m_data_o,
  output logic           m_last_o,
  input  logic           m_ready_i
);
  localparam int CNT_W  = $clog2(LANES + 1);
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int GUARD  = 2 * LANES;  // room for one late word

  logic [LANES*8-1:0] pk_bytes;
  logic [CNT_W-1:0]   pk_cnt;
  logic [FILL_W-1:0]  fill, free;
  logic               accept;

  assign bus_clk_o = clk;

  sfw_lane_pack #(.LANES(LANES), .CNT_W(CNT_W)) pack_i (
    .data_i   (data_i[LANES*8-1:0]),
    .be_i     (be_i[LANES-1:0]),
    .packed_o (pk_bytes),
    .cnt_o    (pk_cnt)
  );

  assign free    = FILL_W'(DEPTH) - fill;
  assign accept  = !wr_n_i && (FILL_W'(pk_cnt) <= free);
  assign txe_n_o = free < FILL_W'(GUARD);

  sfw_byte_ring #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W), .FILL_W(FILL_W)) ring_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (accept),
    .wr_cnt_i   (pk_cnt),
    .wr_bytes_i (pk_bytes),
    .idle_i     (wr_n_i),
    .rd_valid_o (m_valid_o),
    .rd_data_o  (m_data_o),
    .rd_last_o  (m_last_o),
    .rd_ready_i (m_ready_i),
    .fill_o     (fill)
  );

  // R4: every strobed word fits, given the master honours the flag within a cycle
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_i |-> (FILL_W'(pk_cnt) <= free));
endmodule

// File: tb/sfw_write_slave_tb_top.sv
module sfw_write_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NTBL = 10;
  // {length in bytes, first byte, ready mode, late master}
  localparam logic [31:0] TBL [NTBL] = '{
    {16'd1,  8'h10, 4'd0, 4'd0},
    {16'd2,  8'h20, 4'd1, 4'd0},
    {16'd3,  8'h30, 4'd2, 4'd0},
    {16'd4,  8'h40, 4'd0, 4'd1},
    {16'd5,  8'h50, 4'd2, 4'd1},
    {16'd7,  8'h60, 4'd3, 4'd0},
    {16'd13, 8'h70, 4'd1, 4'd1},
    {16'd40, 8'h80, 4'd3, 4'd0},
    {16'd64, 8'h01, 4'd3, 4'd1},
    {16'd31, 8'hA0, 4'd2, 4'd1}
  };

  logic clk = 0, rst_n = 0;
  logic bus_clk_o, wr_n_i = 1, txe_n_o, m_valid_o, m_last_o, m_ready_i;
  logic [31:0] data_i = '1;
  logic [3:0]  be_i = '1;
  logic [7:0]  m_data_o;

  int total = 0, bad = 0;
  int n_exp = 0, n_rx = 0, rmode = 4;
  bit open_exp = 0, finished = 0;
  logic [7:0] exp_byte [4096];
  bit         exp_last [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  sfw_write_slave dut_i (
    .clk(clk), .rst_n(rst_n), .bus_clk_o(bus_clk_o), .wr_n_i(wr_n_i),
    .data_i(data_i), .be_i(be_i), .txe_n_o(txe_n_o), .m_valid_o(m_valid_o),
    .m_data_o(m_data_o), .m_last_o(m_last_o), .m_ready_i(m_ready_i)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic put_word(input logic [31:0] d, input logic [3:0] b);
    wr_n_i = 0; data_i = d; be_i = b;
    for (int j = 0; j < 4; j++) begin
      if (b[j]) begin
        exp_byte[n_exp] = d[j*8 +: 8];
        exp_last[n_exp] = 0;
        n_exp++;
        open_exp = 1;
      end
    end
  endtask

  task automatic put_idle();
    wr_n_i = 1; data_i = '1; be_i = '1;
    if (open_exp) begin
      exp_last[n_exp-1] = 1;
      open_exp = 0;
    end
  endtask

  task automatic send_burst(input int len, input logic [7:0] seed, input bit late);
    int rem = len, k = 0;
    logic prev = txe_n_o, cur, view;
    while (rem > 0) begin
      @(negedge clk);
      cur = txe_n_o;
      view = late ? prev : cur;
      prev = cur;
      if (!view) begin
        int n = (rem < 4) ? rem : 4;
        logic [31:0] d;
        for (int j = 0; j < 4; j++) d[j*8 +: 8] = seed + 8'(k + j);
        put_word(d, 4'((1 << n) - 1));
        rem -= n;
        k += n;
      end else begin
        put_idle();
      end
    end
    @(negedge clk);
    put_idle();
  endtask

  task automatic drain(input string tag);
    int t = 0;
    rmode = 0;
    while (n_rx != n_exp && t < 3000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(n_rx == n_exp && !m_valid_o, tag, n_rx, n_exp);
  endtask

  // consumer and scoreboard
  initial begin
    bit hold_pend = 0;
    logic [7:0] hold_d = '0;
    logic hold_l = 0;
    m_ready_i = 0;
    forever begin
      @(negedge clk);
      case (rmode)
        0: m_ready_i = 1;
        1: m_ready_i = ~m_ready_i;
        2: m_ready_i = 1'($urandom % 2);
        3: m_ready_i = ($urandom % 4) == 0;
        default: m_ready_i = 0;
      endcase
      if (rst_n) begin
        if (hold_pend)  // R8 stall stability
          chk(m_valid_o && m_data_o == hold_d && m_last_o == hold_l, "R8 hold",
              {m_valid_o, m_last_o, m_data_o}, {1'b1, hold_l, hold_d});
        hold_pend = m_valid_o && !m_ready_i;
        hold_d = m_data_o;
        hold_l = m_last_o;
        if (m_valid_o && m_ready_i) begin
          if (n_rx >= n_exp) begin
            chk(0, "R8 extra byte", m_data_o, 0);
          end else begin
            chk(m_data_o == exp_byte[n_rx], "R2 data order", m_data_o, exp_byte[n_rx]);
            chk(m_last_o == exp_last[n_rx], "R5 last marker", m_last_o, exp_last[n_rx]);
          end
          n_rx++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(txe_n_o == 0 && m_valid_o == 0, "R1 in reset", {txe_n_o, m_valid_o}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(txe_n_o == 0 && m_valid_o == 0, "R1 after reset", {txe_n_o, m_valid_o}, 0);
    chk(bus_clk_o === clk, "R9 clock low", bus_clk_o, clk);
    @(posedge clk); #1;
    chk(bus_clk_o === clk, "R9 clock high", bus_clk_o, clk);

    // table-driven bursts
    for (int e = 0; e < NTBL; e++) begin
      rmode = int'(TBL[e][7:4]);
      send_burst(int'(TBL[e][31:16]), TBL[e][15:8], TBL[e][0]);
      drain("R4 table burst drained");
    end

    // R3: space flag threshold
    rmode = 4;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      put_word({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)}, 4'hF);
      @(negedge clk);
      chk(txe_n_o == (i >= 7), "R3 flag vs fill", txe_n_o, (i >= 7));
      put_idle();
    end
    @(negedge clk);
    chk(txe_n_o == 1, "R3 flag after close", txe_n_o, 1);
    drain("R3 drain");
    chk(txe_n_o == 0, "R3 flag after drain", txe_n_o, 0);

    // R2: non-contiguous enables
    @(negedge clk); put_word(32'hD4C3B2A1, 4'b1010);
    @(negedge clk); put_idle();
    drain("R2 sparse enables");

    // R6 and R7: held newest byte, empty trailing words
    rmode = 4;
    @(negedge clk); put_word(32'h000000E7, 4'b0001);
    @(negedge clk); put_word(32'h11111111, 4'b0000);
    chk(m_valid_o == 0, "R6 newest byte held", m_valid_o, 0);
    @(negedge clk); put_word(32'h22222222, 4'b0000);
    chk(m_valid_o == 0, "R7 empty word adds nothing", m_valid_o, 0);
    @(negedge clk); put_idle();
    chk(m_valid_o == 0, "R6 still held at close", m_valid_o, 0);
    @(negedge clk);
    chk(m_valid_o && m_last_o && m_data_o == 8'hE7, "R6 released with last",
        {m_valid_o, m_last_o, m_data_o}, {2'b11, 8'hE7});
    drain("R7 drain");

    // R7: burst with no enabled bytes
    @(negedge clk); put_word(32'h33333333, 4'b0000);
    @(negedge clk); put_idle();
    repeat (3) @(negedge clk);
    chk(m_valid_o == 0 && n_rx == n_exp, "R7 empty burst silent", m_valid_o, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule